// File: doc/BRIEF.md
# Chainable Converter Serial Readout Port

This block forms the digital half of a 20-bit converter's serial output. A rising edge on the convert input starts a conversion. A busy flag then stays high for a fixed number of system clock cycles. When busy drops, the parallel result (a two's complement word) is captured into an output shift register. A host reads the word out most significant bit first by pulsing a serial clock. The convert input, the serial clock and the shared pin all cross into the system clock domain through two-flop synchronizers. Edges are then found by comparing against one further delayed copy.

A mode strap sets the role of one shared pin. In normal mode the pin is an active-high read enable. While it is low, the serial output is released, which is modelled as an output-enable signal, and the bits shifted in behind the result are zero. In chain mode the output is always enabled and the shared pin becomes a serial data input. Every serial clock edge samples one bit from it into the register's least significant end. As a result, after a device's own word the output carries whatever the upstream device sent, and several devices on one line deliver their words back to back.

Top module: `adc_serial_port`

## Requirements
- R1: While reset is asserted and right after it is released, busy is low, the serial output is 0, and in normal mode the output enable is low.
- R2: If the convert input rises before system clock edge k, busy is low after edges k and k+1 and is high after edge k+2.
- R3: Busy stays high for exactly CONV_CYCLES system clock cycles per conversion.
- R4: On the cycle busy falls, the parallel result is loaded, and the serial output shows its most significant bit.
- R5: Each rising serial clock edge advances the output by one bit, most significant first. The new bit is visible after the third system clock edge following the serial clock change.
- R6: A convert rising edge that arrives while busy is high is ignored: busy falls at the time set by the first edge and does not rise again.
- R7: In normal mode (strap low) the output enable follows the shared pin, synchronized by two system clock edges (1 = enabled). A zero enters behind the result on each shift, so after WIDTH shifts the output reads 0.
- R8: In chain mode (strap high) the output enable is always 1. The shared pin is sampled on each serial clock edge into the least significant bit, so the output bit read after WIDTH+j shifts equals the bit presented on shift j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_i | input | 1 | Convert request; a rising edge starts a conversion |
| result_i | input | WIDTH | Parallel conversion result, two's complement |
| chain_mode_i | input | 1 | Mode strap: 0 normal, 1 chain |
| share_i | input | 1 | Read enable (normal) or upstream serial data (chain) |
| sclk_i | input | 1 | Serial clock; each rising edge shifts one bit |
| busy_o | output | 1 | High while a conversion is in progress |
| sdo_o | output | 1 | Serial data output |
| sdo_oe_o | output | 1 | Output enable for the serial data line |

## Verification
Each result has a fixed due time. Busy is due three system edges after the convert change and stays for exactly CONV_CYCLES cycles. Each new serial bit is due three edges after a serial clock rise, and the enable follows the shared pin after two edges. The bench changes inputs on the falling clock edge and holds each serial clock phase for four cycles. Its monitor compares the serial output at the falling edge just before the next pulse, which falls safely after every due time. Busy is checked at the exact edges before and after its expected rise, and its high time is counted cycle by cycle.

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int WIDTH       = 20,
  parameter int CONV_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic [WIDTH-1:0] result_i,
  input  logic             chain_mode_i,
  input  logic             share_i,
  input  logic             sclk_i,
  output logic             busy_o,
  output logic             sdo_o,
  output logic             sdo_oe_o
);
  localparam int CW = $clog2(CONV_CYCLES + 1);

  logic [2:0]       cnv_q, sclk_q;
  logic [1:0]       share_q;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] shreg;
  logic             cnv_rise, sclk_rise, load, in_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnv_q   <= '0;
      sclk_q  <= '0;
      share_q <= '0;
    end else begin
      cnv_q   <= {cnv_q[1:0], cnv_i};
      sclk_q  <= {sclk_q[1:0], sclk_i};
      share_q <= {share_q[0], share_i};
    end

  assign cnv_rise  = cnv_q[1] & ~cnv_q[2];
  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign load      = busy_o && (cnt == '0);
  assign in_bit    = chain_mode_i & share_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      busy_o <= 1'b0;
      cnt    <= '0;
    end else if (!busy_o && cnv_rise) begin
      busy_o <= 1'b1;
      cnt    <= CW'(CONV_CYCLES - 1);
    end else if (load) begin
      busy_o <= 1'b0;
    end else if (busy_o) begin
      cnt    <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         shreg <= '0;
    else if (load)      shreg <= result_i;
    else if (sclk_rise) shreg <= {shreg[WIDTH-2:0], in_bit};

  assign sdo_o    = shreg[WIDTH-1];
  assign sdo_oe_o = chain_mode_i | share_q[1];

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(cnv_rise));

  assert_load_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> shreg == $past(result_i));

  assert_shift_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !load) |=> sdo_o == $past(shreg[WIDTH-2]));

  assert_ignore_retrigger_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cnv_rise && cnt != '0) |=> (busy_o && cnt == $past(cnt) - 1'b1));

  assert_chain_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && !load && chain_mode_i) |=> shreg[0] == $past(share_q[1]));
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb_top;
  localparam int WIDTH = 20;
  localparam int CONV  = 40;

  logic clk = 0, rst_n = 0, cnv = 0, chain = 0, share = 0, sclk = 0;
  logic [WIDTH-1:0] result = '0;
  logic busy, sdo, sdo_oe;
  int checks = 0, errors = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];
  event  sample_ev;

  always #5 clk = ~clk;

  adc_serial_port #(.WIDTH(WIDTH), .CONV_CYCLES(CONV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .result_i(result),
    .chain_mode_i(chain), .share_i(share), .sclk_i(sclk),
    .busy_o(busy), .sdo_o(sdo), .sdo_oe_o(sdo_oe));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(sample_ev);
    if (exp_q.size() == 0) check(1, 0, "queue underflow");
    else check(sdo, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic push(input logic b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic sclk_pulse(input logic sdi);
    @(negedge clk) begin sclk = 1; if (chain) share = sdi; end
    repeat (4) @(negedge clk);
    sclk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic convert(input logic [WIDTH-1:0] val, input bit retrig);
    int n;
    result = val;
    @(negedge clk) cnv = 1;
    repeat (2) @(posedge clk);
    @(negedge clk) check(busy, 0, "R2 busy before third edge");
    @(posedge clk);
    @(negedge clk) check(busy, 1, "R2 busy after third edge");
    n = 1;
    while (busy) begin
      @(negedge clk);
      if (busy) n++;
      if (n == 5) cnv = 0;
      if (n == 12 && retrig) cnv = 1;
    end
    check(n, CONV, "R3 busy length");
    check(sdo, val[WIDTH-1], "R4 msb after load");
    repeat (5) @(negedge clk);
    check(busy, 0, retrig ? "R6 no retrigger" : "R3 idle");
    cnv = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_normal(input logic [WIDTH-1:0] val);
    for (int i = 0; i < WIDTH; i++) begin
      push(val[WIDTH-1-i], "R5 normal bit");
      -> sample_ev;
      #1 sclk_pulse(1'b0);
    end
    push(1'b0, "R7 zero fill");
    -> sample_ev;
    #1;
  endtask

  task automatic read_chain(input logic [WIDTH-1:0] val, input logic [WIDTH-1:0] up);
    for (int i = 0; i < 2*WIDTH; i++) begin
      if (i < WIDTH) push(val[WIDTH-1-i], "R5 chain own bit");
      else push(up[WIDTH-1-(i-WIDTH)], "R8 upstream bit");
      -> sample_ev;
      #1 sclk_pulse(i < WIDTH ? up[WIDTH-1-i] : 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy, 0, "R1 busy in reset");
    check(sdo, 0, "R1 sdo in reset");
    check(sdo_oe, 0, "R1 oe in reset");
    rst_n = 1;
    @(negedge clk);
    check(busy, 0, "R1 busy after reset");
    check(sdo, 0, "R1 sdo after reset");

    share = 1;
    repeat (2) @(negedge clk);
    check(sdo_oe, 1, "R7 enable on");
    share = 0;
    repeat (2) @(negedge clk);
    check(sdo_oe, 0, "R7 enable off");

    convert(20'hA5C3E, 0);
    read_normal(20'hA5C3E);
    convert(20'h80001, 1);
    read_normal(20'h80001);
    convert(20'h7FFFF, 0);
    read_normal(20'h7FFFF);

    chain = 1;
    share = 0;
    repeat (3) @(negedge clk);
    check(sdo_oe, 1, "R8 oe in chain mode");
    convert(20'h3C96B, 0);
    read_chain(20'h3C96B, 20'hD2F41);
    convert(20'hFFFFF, 1);
    read_chain(20'hFFFFF, 20'h00000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule